// File: doc/BRIEF.md
# Register-Pointer Serial Slave with Alert Response

This block is the serial-bus front end of a monitoring device. It is a two-wire slave with a fixed 7-bit address. It gives a host access to sixteen byte-wide registers through a pointer. A write transfer loads the pointer and then stores data bytes at successive locations. A read transfer follows a repeated START and streams bytes out from the pointer. The pointer advances after every stored byte. It also advances after every transmitted byte that the host acknowledges. The register storage itself sits outside the block. The block presents a combinational read address and takes the read data back in the same cycle. It issues single-cycle write and read strobes. It also issues a clear strobe whenever the status byte at location 0 is loaded for transmission, so that the status logic can clear its sticky bits.

The block also carries the shared-alert side of the bus. An alert event latches a pending flag. While the alert pin is configured for alert mode, the flag pulls an open-drain alert line low. When a host reads from the alert response address, a pending slave acknowledges and sends its own address with the read bit set, arbitrating bit by bit against other slaves. A slave that loses releases the line and keeps its alert for the next response cycle. A slave that wins drops its alert and ignores further response reads until a new event arrives.

SCL and SDA are sampled by the system clock through a synchronizer. SDA is driven only through a pull-down enable.

Top module: `i2c_alert_slave`

## Requirements
- R1: After reset, sda_pd_o and alert_pd_o are 0 and reg_wr_o, reg_rd_o and stat_clr_o are idle.
- R2: A write is address 0x64 with R/W=0, then a pointer byte (the low 4 bits are used), then data bytes. Each byte is acknowledged. Each data byte produces one reg_wr_o pulse with reg_addr_o at the pointer, and then the pointer increments modulo 16 (15 wraps to 0).
- R3: After a repeated START with address 0x64 and R/W=1, the block sends the register at the pointer MSB first. A host ACK (SDA=0 in the ninth slot) advances the pointer and starts the next byte. A host NAK ends the transfer with SDA released.
- R4: Any other address, and the alert response address with R/W=0, is not acknowledged (SDA stays high in the ninth slot) and produces no strobe.
- R5: sda_pd_o changes only while the synchronized SCL is low. It is released during the host's acknowledge slot of a read.
- R6: stat_clr_o pulses together with reg_rd_o exactly when a byte is loaded from location 0 for transmission. Loads from other locations do not pulse it.
- R7: An alert_evt_i pulse makes the alert pending. alert_pd_o is 1 only while an alert is pending and alert_cfg_i is 2'b10. The values 2'b01 (charge-complete input), 2'b00 (disabled) and 2'b11 (not allowed) keep the pin released, and the pending alert is kept.
- R8: Address 0x0C with R/W=1 is acknowledged only while alert_pd_o is 1. The block then sends its address followed by a 1, which is byte 0xC9.
- R9: If the block releases SDA for a 1 during an alert response and samples 0 at the SCL rise, it stops driving for the rest of the transfer and keeps its alert pending for the next response.
- R10: After the block sends its whole response byte, alert_pd_o drops, and later response reads are not acknowledged until a new alert_evt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | Pull-down enable for the data line |
| alert_evt_i | input | 1 | One-cycle pulse for a new alert event |
| alert_cfg_i | input | 2 | Alert pin mode: 10 alert, 01 charge-complete input, 00 off, 11 not allowed |
| alert_pd_o | output | 1 | Pull-down enable for the alert line |
| reg_addr_o | output | 4 | Register pointer, used as both read and write address |
| reg_wdata_o | output | 8 | Write data |
| reg_wr_o | output | 1 | Write strobe |
| reg_rd_o | output | 1 | Strobe for a byte loaded for transmission |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational |
| stat_clr_o | output | 1 | Clear-on-read strobe for location 0 |

## Verification
The bench uses the default parameters: slave address 0x64, alert response address 0x0C, a 4-bit pointer and a two-stage synchronizer. With only sixteen locations, pointer wrap from 15 to 0 occurs within one burst, in both write and read directions. The fixed address 0x64 begins with a 1, so a competing responder with address 0x20 wins on the very first bit. That case exercises the lost-arbitration path, and the retry afterwards is checked.

// File: rtl/i2c_alert_slave_pkg.sv
package i2c_alert_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_OUT, ST_TX, ST_TX_ACK, ST_WAIT
  } state_e;

  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rx_kind_e;

  typedef enum logic [1:0] {NX_PTR, NX_DATA, NX_TXREG, NX_TXARA} next_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
  // data edges while clock stays high
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_alert_tracker.sv
module i2c_alert_tracker (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  logic       win_i,
  input  logic [1:0] cfg_i,
  output logic       active_o
);
  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pending_q <= 1'b0;
    else if (evt_i)  pending_q <= 1'b1;
    else if (win_i)  pending_q <= 1'b0;
  end

  assign active_o = pending_q & (cfg_i == 2'b10);
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_alert_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h64,
  parameter logic [6:0] ARA_ADDR = 7'h0C,
  parameter int         AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          alert_active_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_pd_o,
  output logic [AW-1:0] ptr_o,
  output logic [7:0]    wdata_o,
  output logic          wr_o,
  output logic          rd_o,
  output logic          clr_o,
  output logic          win_o
);
  localparam logic [7:0] ARA_REPLY = {DEV_ADDR, 1'b1};

  state_e        state;
  rx_kind_e      rx_kind;
  next_e         nxt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh;
  logic          done, ack, is_ara;
  logic [AW-1:0] ptr;
  logic [7:0]    rx_byte;

  assign rx_byte = {sh[6:0], sda_i};
  assign ptr_o   = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      rx_kind  <= RX_ADDR;
      nxt      <= NX_PTR;
      bit_cnt  <= '0;
      sh       <= '0;
      done     <= 1'b0;
      ack      <= 1'b0;
      is_ara   <= 1'b0;
      ptr      <= '0;
      sda_pd_o <= 1'b0;
      wdata_o  <= '0;
      wr_o     <= 1'b0;
      rd_o     <= 1'b0;
      clr_o    <= 1'b0;
      win_o    <= 1'b0;
    end else begin
      wr_o  <= 1'b0;
      rd_o  <= 1'b0;
      clr_o <= 1'b0;
      win_o <= 1'b0;
      if (stop_i) begin
        state    <= ST_IDLE;
        sda_pd_o <= 1'b0;
      end else if (start_i) begin
        state    <= ST_RX;
        rx_kind  <= RX_ADDR;
        bit_cnt  <= '0;
        done     <= 1'b0;
        sda_pd_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (rise_i && !done) begin
              sh      <= rx_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                done <= 1'b1;
                unique case (rx_kind)
                  RX_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR) begin
                      ack <= 1'b1;
                      nxt <= rx_byte[0] ? NX_TXREG : NX_PTR;
                    end else if (rx_byte[7:1] == ARA_ADDR && rx_byte[0] && alert_active_i) begin
                      ack <= 1'b1;
                      nxt <= NX_TXARA;
                    end else begin
                      ack <= 1'b0;
                    end
                  end
                  RX_PTR: begin
                    ptr <= rx_byte[AW-1:0];
                    ack <= 1'b1;
                    nxt <= NX_DATA;
                  end
                  default: begin
                    wdata_o <= rx_byte;
                    wr_o    <= 1'b1;
                    ack     <= 1'b1;
                    nxt     <= NX_DATA;
                  end
                endcase
              end
            end else if (fall_i && done) begin
              done <= 1'b0;
              if (ack) begin
                state    <= ST_ACK_OUT;
                sda_pd_o <= 1'b1;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ACK_OUT: begin
            if (fall_i) begin
              bit_cnt <= '0;
              done    <= 1'b0;
              unique case (nxt)
                NX_PTR: begin
                  state    <= ST_RX;
                  rx_kind  <= RX_PTR;
                  sda_pd_o <= 1'b0;
                end
                NX_DATA: begin
                  state    <= ST_RX;
                  sda_pd_o <= 1'b0;
                  if (rx_kind == RX_DATA) ptr <= ptr + 1'b1;
                  rx_kind  <= RX_DATA;
                end
                NX_TXREG: begin
                  state    <= ST_TX;
                  is_ara   <= 1'b0;
                  sh       <= rdata_i;
                  rd_o     <= 1'b1;
                  clr_o    <= (ptr == '0);
                  sda_pd_o <= ~rdata_i[7];
                end
                default: begin
                  state    <= ST_TX;
                  is_ara   <= 1'b1;
                  sh       <= ARA_REPLY;
                  sda_pd_o <= ~ARA_REPLY[7];
                end
              endcase
            end
          end
          ST_TX: begin
            if (rise_i && !done) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (is_ara && !sda_pd_o && !sda_i) begin
                state <= ST_WAIT;  // lost arbitration
              end else if (bit_cnt == 3'd7) begin
                done  <= 1'b1;
                win_o <= is_ara;
              end
            end else if (fall_i && !done) begin
              sh       <= {sh[6:0], 1'b0};
              sda_pd_o <= ~sh[6];
            end else if (fall_i && done) begin
              done     <= 1'b0;
              sda_pd_o <= 1'b0;
              state    <= ST_TX_ACK;
            end
          end
          ST_TX_ACK: begin
            if (rise_i && !done) begin
              if (!sda_i && !is_ara) begin
                ptr  <= ptr + 1'b1;
                done <= 1'b1;
              end else begin
                state <= ST_WAIT;
              end
            end else if (fall_i && done) begin
              done     <= 1'b0;
              bit_cnt  <= '0;
              sh       <= rdata_i;
              rd_o     <= 1'b1;
              clr_o    <= (ptr == '0);
              sda_pd_o <= ~rdata_i[7];
              state    <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_alert_slave.sv
module i2c_alert_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h64,
  parameter logic [6:0] ARA_ADDR    = 7'h0C,
  parameter int         AW          = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  input  logic          alert_evt_i,
  input  logic [1:0]    alert_cfg_i,
  output logic          alert_pd_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_wr_o,
  output logic          reg_rd_o,
  input  logic [7:0]    reg_rdata_i,
  output logic          stat_clr_o
);
  logic scl_q, sda_q, scl_rise, scl_fall, bus_start, bus_stop;
  logic ara_win, alert_active;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_q),
    .sda_o   (sda_q),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (bus_start),
    .stop_o  (bus_stop)
  );

  i2c_alert_tracker u_alert (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (alert_evt_i),
    .win_i    (ara_win),
    .cfg_i    (alert_cfg_i),
    .active_o (alert_active)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .ARA_ADDR(ARA_ADDR), .AW(AW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sda_i          (sda_q),
    .rise_i         (scl_rise),
    .fall_i         (scl_fall),
    .start_i        (bus_start),
    .stop_i         (bus_stop),
    .alert_active_i (alert_active),
    .rdata_i        (reg_rdata_i),
    .sda_pd_o       (sda_pd_o),
    .ptr_o          (reg_addr_o),
    .wdata_o        (reg_wdata_o),
    .wr_o           (reg_wr_o),
    .rd_o           (reg_rd_o),
    .clr_o          (stat_clr_o),
    .win_o          (ara_win)
  );

  assign alert_pd_o = alert_active;
endmodule

// File: rtl/i2c_alert_slave_chk.sv
module i2c_alert_slave_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_q,
  input logic          sda_pd_o,
  input logic          alert_evt_i,
  input logic [1:0]    alert_cfg_i,
  input logic          alert_pd_o,
  input logic          ara_win,
  input logic [AW-1:0] reg_addr_o,
  input logic          reg_wr_o,
  input logic          reg_rd_o,
  input logic          stat_clr_o
);
  a_r5_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_q);

  a_r7_alert_mode_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_pd_o |-> alert_cfg_i == 2'b10);

  a_r6_clear_on_loc0_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_o |-> (reg_rd_o && reg_addr_o == '0));

  a_r2_single_write_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r10_release_on_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_win && !alert_evt_i) |=> !alert_pd_o);

  a_r3_no_wr_rd_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
endmodule

bind i2c_alert_slave i2c_alert_slave_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_q       (scl_q),
  .sda_pd_o    (sda_pd_o),
  .alert_evt_i (alert_evt_i),
  .alert_cfg_i (alert_cfg_i),
  .alert_pd_o  (alert_pd_o),
  .ara_win     (ara_win),
  .reg_addr_o  (reg_addr_o),
  .reg_wr_o    (reg_wr_o),
  .reg_rd_o    (reg_rd_o),
  .stat_clr_o  (stat_clr_o)
);

// File: tb/i2c_alert_slave_tb.sv
`timescale 1ns/1ps
module i2c_alert_slave_tb;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1, rival_pd = 1'b0;
  logic       sda_pd, alert_pd, alert_evt = 1'b0;
  logic [1:0] alert_cfg = 2'b10;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, stat_clr;
  wire        sda_bus = sda_m & ~sda_pd & ~rival_pd;

  i2c_alert_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pd_o(sda_pd),
    .alert_evt_i(alert_evt), .alert_cfg_i(alert_cfg), .alert_pd_o(alert_pd),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr),
    .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata), .stat_clr_o(stat_clr)
  );

  // register file model
  logic [7:0] mem [16];
  int wr_cnt, rd_cnt, clr_cnt, viol_cnt;
  logic pd_prev;
  assign reg_rdata = mem[reg_addr];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h30 + 8'(i);
      wr_cnt <= 0; rd_cnt <= 0; clr_cnt <= 0; viol_cnt <= 0; pd_prev <= 1'b0;
    end else begin
      if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
      if (stat_clr) clr_cnt <= clr_cnt + 1;
      pd_prev <= sda_pd;
      if (scl_m && sda_pd != pd_prev) viol_cnt <= viol_cnt + 1;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_h(); repeat (H) @(negedge clk); endtask
  task automatic bit_x(input logic b, input logic rb, output logic r);
    repeat (2) @(negedge clk);
    sda_m = b; rival_pd = rb;
    wait_h(); scl_m = 1'b1; wait_h();
    r = sda_bus; scl_m = 1'b0;
  endtask
  task automatic bus_start();
    repeat (2) @(negedge clk); rival_pd = 1'b0;
    sda_m = 1'b1; wait_h(); scl_m = 1'b1; wait_h(); sda_m = 1'b0; wait_h(); scl_m = 1'b0;
  endtask
  task automatic bus_stop();
    repeat (2) @(negedge clk); rival_pd = 1'b0;
    sda_m = 1'b0; wait_h(); scl_m = 1'b1; wait_h(); sda_m = 1'b1; wait_h();
  endtask
  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], 1'b0, r);
    bit_x(1'b1, 1'b0, r);
    ack = ~r;
  endtask
  task automatic rd_byte(input logic last, input logic rival_on, input logic [7:0] rival,
                         output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, rival_on & ~rival[i], r);
      d[i] = r;
    end
    bit_x(last, 1'b0, r);
  endtask
  task automatic write_one(input logic [3:0] p, input logic [7:0] d);
    logic a;
    bus_start(); wr_byte(8'hC8, a); wr_byte({4'h0, p}, a); wr_byte(d, a); bus_stop();
  endtask
  task automatic read_one(input logic [3:0] p, output logic [7:0] d);
    logic a;
    bus_start(); wr_byte(8'hC8, a); wr_byte({4'h0, p}, a);
    bus_start(); wr_byte(8'hC9, a); rd_byte(1'b1, 1'b0, 8'h00, d); bus_stop();
  endtask

  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {4'h2, 8'hA5}, {4'h5, 8'h5A}, {4'h9, 8'hFF}, {4'hF, 8'h00}, {4'h1, 8'h3C}, {4'hC, 8'h81}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int w0, c0, r0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sda_pd", sda_pd, 0);
    chk("R1 alert_pd", alert_pd, 0);
    chk("R1 strobes", {reg_wr, reg_rd, stat_clr}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2/R3 table walk: write one byte, read it back
    for (int v = 0; v < NV; v++) begin
      write_one(VEC[v][11:8], VEC[v][7:0]);
      chk("R2 stored", mem[VEC[v][11:8]], VEC[v][7:0]);
      read_one(VEC[v][11:8], d);
      chk("R3 readback", d, VEC[v][7:0]);
    end

    // R2 burst write with wrap 15 -> 0
    w0 = wr_cnt;
    bus_start(); wr_byte(8'hC8, a); chk("R2 addr ack", a, 1);
    wr_byte(8'h0E, a); wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    chk("R2 data ack", a, 1);
    bus_stop();
    chk("R2 loc14", mem[14], 8'h11);
    chk("R2 loc15", mem[15], 8'h22);
    chk("R2 wrap loc0", mem[0], 8'h33);
    chk("R2 strobe count", wr_cnt - w0, 3);

    // R3/R6 burst read with wrap, ACK ACK NAK
    r0 = rd_cnt; c0 = clr_cnt;
    bus_start(); wr_byte(8'hC8, a); wr_byte(8'h0E, a);
    bus_start(); wr_byte(8'hC9, a); chk("R3 read addr ack", a, 1);
    rd_byte(1'b0, 1'b0, 8'h00, d); chk("R3 byte0", d, 8'h11);
    rd_byte(1'b0, 1'b0, 8'h00, d); chk("R3 byte1", d, 8'h22);
    rd_byte(1'b1, 1'b0, 8'h00, d); chk("R3 wrap byte2", d, 8'h33);
    chk("R3 released after NAK", sda_pd, 0);
    bus_stop();
    chk("R3 load count", rd_cnt - r0, 3);
    chk("R6 one clear on loc0", clr_cnt - c0, 1);

    // R6 read of a non-zero location does not clear
    c0 = clr_cnt;
    read_one(4'h3, d);
    chk("R6 no clear loc3", clr_cnt - c0, 0);
    read_one(4'h0, d);
    chk("R6 clear loc0", clr_cnt - c0, 1);

    // R4 foreign addresses
    w0 = wr_cnt;
    bus_start(); wr_byte(8'hCA, a); chk("R4 nak 0x65", a, 0);
    wr_byte(8'h02, a); wr_byte(8'hEE, a); bus_stop();
    bus_start(); wr_byte(8'h18, a); chk("R4 nak ARA write", a, 0); bus_stop();
    chk("R4 no write", wr_cnt - w0, 0);
    chk("R4 loc2 kept", mem[2], 8'hA5);

    // R8 response read without alert
    bus_start(); wr_byte(8'h19, a); chk("R8 nak no alert", a, 0); bus_stop();

    // R7 alert pin and modes
    @(negedge clk); alert_evt = 1'b1; @(negedge clk); alert_evt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 alert asserted", alert_pd, 1);
    alert_cfg = 2'b01; @(negedge clk); chk("R7 cc mode released", alert_pd, 0);
    alert_cfg = 2'b11; @(negedge clk); chk("R7 mode 11 released", alert_pd, 0);
    alert_cfg = 2'b00; @(negedge clk); chk("R7 off released", alert_pd, 0);
    bus_start(); wr_byte(8'h19, a); chk("R8 nak when pin off", a, 0); bus_stop();
    alert_cfg = 2'b10; @(negedge clk); chk("R7 pending kept", alert_pd, 1);

    // R9 lose arbitration to rival 0x20
    bus_start(); wr_byte(8'h19, a); chk("R9 ack", a, 1);
    rd_byte(1'b1, 1'b1, 8'h41, d); bus_stop();
    chk("R9 rival byte", d, 8'h41);
    chk("R9 alert kept", alert_pd, 1);

    // R8/R10 win
    bus_start(); wr_byte(8'h19, a); chk("R8 ack", a, 1);
    rd_byte(1'b1, 1'b0, 8'h00, d); bus_stop();
    chk("R8 reply byte", d, 8'hC9);
    chk("R10 alert released", alert_pd, 0);
    bus_start(); wr_byte(8'h19, a); chk("R10 nak after win", a, 0); bus_stop();
    @(negedge clk); alert_evt = 1'b1; @(negedge clk); alert_evt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 new event", alert_pd, 1);
    bus_start(); wr_byte(8'h19, a); chk("R10 ack after new event", a, 1);
    rd_byte(1'b1, 1'b0, 8'h00, d); bus_stop();
    chk("R10 reply again", d, 8'hC9);

    // R5 no SDA change while SCL high
    chk("R5 sda stable while scl high", viol_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule